// File: doc/BRIEF.md
# Three-Channel Tone, Noise and Mixer Core

This block is the waveform half of a programmable sound generator. From a shared master tick it runs three independent square-wave tone dividers and one pseudo-random noise source. It then merges tone and noise for each channel under an active-low enable mask and turns the merged waveform into a 5-bit amplitude code. The code comes from a fixed 4-bit level or from a live envelope value supplied from outside.

A register file elsewhere holds the periods, the mask and the level words and drives them in as static inputs. An external envelope unit drives the envelope value. The three amplitude codes go to a converter stage. An input clock enable paces the block, and a select input chooses whether every enabled cycle is a master tick or only every second one.

Top module: `ssg_mixer_core`

## Requirements
- R1: With `sel_full` high every cycle with `clk_en` high is a master tick. With `sel_full` low only every second enabled cycle is a master tick, and the first one falls on the second enabled cycle after reset. A cycle with `clk_en` low changes no internal state.
- R2: Each tone wave is low after reset and toggles every 8*TP master ticks, so it has a period of 16*TP ticks. With one tick per cycle its k-th toggle lands on the clock edge 8*TP*k after reset release.
- R3: A tone or noise period of 0 behaves exactly like a period of 1.
- R4: The noise source is a 17-bit shift register seeded to 1 at reset, and its output is bit 0. Each step shifts it right by one and loads bit 16 with bit 0 XOR bit 3. The k-th step lands 16*NP*k master ticks after reset release.
- R5: In the mixer word `mix`, bits 0, 1 and 2 disable tone on channels A, B and C, and bits 3, 4 and 5 disable noise on A, B and C (1 disables). With both sources enabled the channel wave is tone AND noise. With one source enabled the wave is that source. With both disabled the amplitude is 0.
- R6: Bits 7 and 6 of `mix` are I/O direction bits kept for the register map. They have no effect on any amplitude.
- R7: In a level word bit 4 picks the mode. With bit 4 at 0 the amplitude is {bits 3..0, 1}, and with bit 4 at 1 it is `env_lvl`, which is followed combinationally.
- R8: While a channel wave is low its amplitude output is 0.
- R9: After reset all tone waves are low and the noise output is 1. A noise-only channel therefore shows its level at once, and a tone-enabled channel shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Input clock enable |
| sel_full | input | 1 | 1: master tick each enabled cycle; 0: every second |
| tone_per_a | input | 12 | Tone period TP, channel A |
| tone_per_b | input | 12 | Tone period TP, channel B |
| tone_per_c | input | 12 | Tone period TP, channel C |
| noise_per | input | 5 | Noise period NP |
| mix | input | 8 | Active-low source enables; bits 7..6 unused here |
| lvl_a | input | 5 | Level word, channel A |
| lvl_b | input | 5 | Level word, channel B |
| lvl_c | input | 5 | Level word, channel C |
| env_lvl | input | 5 | Envelope value |
| amp_a | output | 5 | Amplitude code, channel A |
| amp_b | output | 5 | Amplitude code, channel B |
| amp_c | output | 5 | Amplitude code, channel C |

## Verification
A fault in the prescaler or in a period counter moves the edges of a tone-enabled channel. This shows up within one half period, 8*TP master ticks, as an amplitude sampled on the wrong side of an expected edge. A wrong feedback tap or seed in the noise register alters the noise-only bit stream after a few steps, because each 16*NP-tick slot exposes one model bit. Mixer or level-select faults show up at once, as a nonzero code where silence is expected or as a code that differs from the selected level.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
    localparam int NCH      = 3;
    localparam int TP_W     = 12;
    localparam int NP_W     = 5;
    localparam int AMP_W    = 5;
    localparam int LFSR_W   = 17;
    localparam int PRE_DIV  = 8;

    // Fixed 4-bit level widened onto the 5-bit envelope scale, or the envelope itself.
    function automatic logic [AMP_W-1:0] pick_level(input logic [AMP_W-1:0] lvl,
                                                    input logic [AMP_W-1:0] env);
        return lvl[AMP_W-1] ? env : {lvl[AMP_W-2:0], 1'b1};
    endfunction
endpackage

// File: rtl/ssg_tick_gen.sv
module ssg_tick_gen #(
    parameter int PRE_DIV = ssg_pkg::PRE_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic sel_full,
    output logic mtick,
    output logic pre_tick
);
    localparam int PRE_W = $clog2(PRE_DIV);

    typedef struct packed {
        logic             half;
        logic [PRE_W-1:0] pre;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        mtick    = clk_en & (sel_full | st_q.half);
        pre_tick = mtick & (st_q.pre == PRE_W'(PRE_DIV - 1));
        if (clk_en) st_d.half = ~st_q.half;
        if (mtick) st_d.pre = pre_tick ? '0 : st_q.pre + PRE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ssg_tone.sv
module ssg_tone #(
    parameter int TP_W = ssg_pkg::TP_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pre_tick,
    input  logic [TP_W-1:0] period,
    output logic            wave
);
    typedef struct packed {
        logic            wave;
        logic [TP_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [TP_W:0] eff;
    logic [TP_W:0] nxt;

    always_comb begin
        st_d = st_q;
        eff  = (period == '0) ? (TP_W+1)'(1) : {1'b0, period};
        nxt  = {1'b0, st_q.cnt} + (TP_W+1)'(1);
        if (pre_tick) begin
            if (nxt >= eff) begin
                st_d.cnt  = '0;
                st_d.wave = ~st_q.wave;
            end else begin
                st_d.cnt = nxt[TP_W-1:0];
            end
        end
        wave = st_q.wave;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ssg_noise.sv
module ssg_noise #(
    parameter int NP_W   = ssg_pkg::NP_W,
    parameter int LFSR_W = ssg_pkg::LFSR_W,
    parameter int TAP_A  = 0,
    parameter int TAP_B  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_tick,
    input  logic [NP_W-1:0]   period,
    output logic              nbit,
    output logic [LFSR_W-1:0] lfsr
);
    typedef struct packed {
        logic [LFSR_W-1:0] sr;
        logic              half;
        logic [NP_W-1:0]   cnt;
    } st_t;

    st_t st_d, st_q;
    logic [NP_W:0] eff;
    logic [NP_W:0] nxt;

    always_comb begin
        st_d = st_q;
        eff  = (period == '0) ? (NP_W+1)'(1) : {1'b0, period};
        nxt  = {1'b0, st_q.cnt} + (NP_W+1)'(1);
        if (pre_tick) begin
            if (nxt >= eff) begin
                st_d.cnt  = '0;
                st_d.half = ~st_q.half;
                if (st_q.half)
                    st_d.sr = {st_q.sr[TAP_A] ^ st_q.sr[TAP_B], st_q.sr[LFSR_W-1:1]};
            end else begin
                st_d.cnt = nxt[NP_W-1:0];
            end
        end
        nbit = st_q.sr[0];
        lfsr = st_q.sr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sr: LFSR_W'(1), half: 1'b0, cnt: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ssg_mixer_core.sv
module ssg_mixer_core #(
    parameter int TP_W   = ssg_pkg::TP_W,
    parameter int NP_W   = ssg_pkg::NP_W,
    parameter int AMP_W  = ssg_pkg::AMP_W,
    parameter int LFSR_W = ssg_pkg::LFSR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             sel_full,
    input  logic [TP_W-1:0]  tone_per_a,
    input  logic [TP_W-1:0]  tone_per_b,
    input  logic [TP_W-1:0]  tone_per_c,
    input  logic [NP_W-1:0]  noise_per,
    input  logic [7:0]       mix,
    input  logic [AMP_W-1:0] lvl_a,
    input  logic [AMP_W-1:0] lvl_b,
    input  logic [AMP_W-1:0] lvl_c,
    input  logic [AMP_W-1:0] env_lvl,
    output logic [AMP_W-1:0] amp_a,
    output logic [AMP_W-1:0] amp_b,
    output logic [AMP_W-1:0] amp_c
);
    import ssg_pkg::*;

    logic                mtick, pre_tick;
    logic [NCH-1:0]      tone_bits;
    logic                noise_bit;
    logic [LFSR_W-1:0]   lfsr;
    logic [TP_W-1:0]     per [NCH];
    logic [AMP_W-1:0]    lvl [NCH];
    logic [AMP_W-1:0]    amp [NCH];
    logic                unused_dir;

    assign per[0] = tone_per_a;
    assign per[1] = tone_per_b;
    assign per[2] = tone_per_c;
    assign lvl[0] = lvl_a;
    assign lvl[1] = lvl_b;
    assign lvl[2] = lvl_c;
    assign unused_dir = ^mix[7:6];

    ssg_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_full(sel_full),
        .mtick(mtick), .pre_tick(pre_tick)
    );

    ssg_noise #(.NP_W(NP_W), .LFSR_W(LFSR_W)) u_noise (
        .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .period(noise_per),
        .nbit(noise_bit), .lfsr(lfsr)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic tdis, ndis, wave;

        ssg_tone #(.TP_W(TP_W)) u_tone (
            .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .period(per[i]),
            .wave(tone_bits[i])
        );

        always_comb begin
            tdis   = mix[i];
            ndis   = mix[i+NCH];
            wave   = (tdis & ndis) ? 1'b0
                                   : ((tone_bits[i] | tdis) & (noise_bit | ndis));
            amp[i] = wave ? pick_level(lvl[i], env_lvl) : '0;
        end
    end

    assign amp_a = amp[0];
    assign amp_b = amp[1];
    assign amp_c = amp[2];
endmodule

// File: rtl/ssg_mixer_chk.sv
module ssg_mixer_chk #(
    parameter int AMP_W  = ssg_pkg::AMP_W,
    parameter int LFSR_W = ssg_pkg::LFSR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              sel_full,
    input logic              mtick,
    input logic              pre_tick,
    input logic [2:0]        tone_bits,
    input logic [LFSR_W-1:0] lfsr,
    input logic [7:0]        mix,
    input logic [AMP_W-1:0]  lvl_a,
    input logic [AMP_W-1:0]  lvl_b,
    input logic [AMP_W-1:0]  env_lvl,
    input logic [AMP_W-1:0]  amp_a,
    input logic [AMP_W-1:0]  amp_b,
    input logic [AMP_W-1:0]  amp_c
);
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mtick && !sel_full) |=> (!mtick || sel_full));

    assert_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(tone_bits) && $stable(lfsr)));

    assert_tone_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_bits != $past(tone_bits)) |-> $past(pre_tick));

    assert_lfsr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr != $past(lfsr)) |->
            ((lfsr[LFSR_W-2:0] == $past(lfsr[LFSR_W-1:1])) &&
             (lfsr[LFSR_W-1] == ($past(lfsr[0]) ^ $past(lfsr[3])))));

    assert_lfsr_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr != '0);

    assert_silent_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mix[0] && mix[3]) |-> (amp_a == '0));
    assert_silent_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mix[1] && mix[4]) |-> (amp_b == '0));
    assert_silent_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mix[2] && mix[5]) |-> (amp_c == '0));

    assert_level_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_a != '0) |-> (amp_a == (lvl_a[4] ? env_lvl : {lvl_a[3:0], 1'b1})));
    assert_level_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_b != '0) |-> (amp_b == (lvl_b[4] ? env_lvl : {lvl_b[3:0], 1'b1})));
endmodule

bind ssg_mixer_core ssg_mixer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_full(sel_full),
    .mtick(mtick), .pre_tick(pre_tick), .tone_bits(tone_bits), .lfsr(lfsr),
    .mix(mix), .lvl_a(lvl_a), .lvl_b(lvl_b), .env_lvl(env_lvl),
    .amp_a(amp_a), .amp_b(amp_b), .amp_c(amp_c)
);

// File: tb/sim_ssg_mixer_core.sv
`timescale 1ns/1ps
module sim_ssg_mixer_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        sel_full = 1'b1;
    logic [11:0] tone_per_a = '0, tone_per_b = '0, tone_per_c = '0;
    logic [4:0]  noise_per = '0;
    logic [7:0]  mix = 8'hFF;
    logic [4:0]  lvl_a = '0, lvl_b = '0, lvl_c = '0, env_lvl = '0;
    logic [4:0]  amp_a, amp_b, amp_c;

    int total = 0;
    int bad = 0;
    int pos = 0;

    always #4 clk = ~clk;

    ssg_mixer_core u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel_full(sel_full),
        .tone_per_a(tone_per_a), .tone_per_b(tone_per_b), .tone_per_c(tone_per_c),
        .noise_per(noise_per), .mix(mix), .lvl_a(lvl_a), .lvl_b(lvl_b), .lvl_c(lvl_c),
        .env_lvl(env_lvl), .amp_a(amp_a), .amp_b(amp_b), .amp_c(amp_c)
    );

    // {tp, sel_full, mix, expected half period in clock edges}
    localparam int NV = 6;
    localparam logic [12+1+8+8-1:0] VEC [NV] = '{
        {12'd1, 1'b1, 8'h3E, 8'd8},
        {12'd0, 1'b1, 8'h3E, 8'd8},
        {12'd3, 1'b1, 8'h3E, 8'd24},
        {12'd2, 1'b0, 8'h3E, 8'd32},
        {12'd5, 1'b1, 8'h3E, 8'd40},
        {12'd1, 1'b1, 8'hFE, 8'd8}
    };

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pos = 0;
    endtask

    // Advance to the negedge following edge number tgt after reset release.
    task automatic adv_to(input int tgt);
        repeat (tgt - pos) @(posedge clk);
        @(negedge clk);
        pos = tgt;
    endtask

    function automatic logic [16:0] nstep(input logic [16:0] m);
        return {m[0] ^ m[3], m[16:1]};
    endfunction

    initial begin
        #1600000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [16:0] m;

        // R9: reset state. Noise-only on A shows level, tone-only on B is 0.
        mix = 8'b00_110_110 | 8'b0000_0010; // A: noise en; B: tone en, noise dis
        mix = 8'b00_110_101;                // A tone dis/noise en, B tone en
        lvl_a = 5'h07; lvl_b = 5'h09;
        tone_per_b = 12'd4; noise_per = 5'd4;
        do_reset();
        adv_to(1);
        chk("R9 noise-only after reset", amp_a, 5'h0F);
        chk("R9 tone low after reset", amp_b, 5'h00);

        // R2/R3/R1/R6: tone vector table on channel A.
        for (int v = 0; v < NV; v++) begin
            int half;
            {tone_per_a, sel_full, mix, half} = {VEC[v][28:17], VEC[v][16], VEC[v][15:8], 32'(VEC[v][7:0])};
            lvl_a = 5'h0A;
            do_reset();
            for (int k = 0; k < 4; k++) begin
                adv_to(half * k + half / 2);
                chk((v == 5) ? "R6 direction bits ignored" :
                    (v == 1) ? "R3 tone period zero" :
                    (v == 3) ? "R1 half-rate master tick" : "R2 tone timing",
                    amp_a, (k % 2 == 1) ? 5'h15 : 5'h00);
            end
        end
        sel_full = 1'b1;

        // R1: clock enable held low freezes the tone.
        clk_en = 1'b0; tone_per_a = 12'd1; mix = 8'h3E;
        do_reset();
        for (int k = 0; k < 4; k++) begin
            adv_to(20 * k + 12);
            chk("R1 enable low freezes", amp_a, 5'h00);
        end
        clk_en = 1'b1;
        do_reset();
        adv_to(12);
        chk("R1 enable high runs", amp_a, 5'h15);

        // R4: noise-only channel B, envelope mode, NP=1 then NP=0.
        for (int pass = 0; pass < 2; pass++) begin
            noise_per = (pass == 0) ? 5'd1 : 5'd0;
            mix = 8'b00_101_111; lvl_b = 5'h10; env_lvl = 5'h13;
            do_reset();
            m = 17'd1;
            for (int k = 0; k < 40; k++) begin
                adv_to(16 * k + 8);
                chk((pass == 0) ? "R4 noise sequence" : "R3 noise period zero",
                    amp_b, m[0] ? 5'h13 : 5'h00);
                m = nstep(m);
            end
        end

        // R4: longer noise period NP=3.
        noise_per = 5'd3;
        do_reset();
        m = 17'd1;
        for (int k = 0; k < 20; k++) begin
            adv_to(48 * k + 24);
            chk("R4 noise period 3", amp_b, m[0] ? 5'h13 : 5'h00);
            m = nstep(m);
        end

        // R5/R8: tone AND noise on channel C.
        noise_per = 5'd1; tone_per_c = 12'd1; mix = 8'b00_011_011; lvl_c = 5'h0F;
        do_reset();
        m = 17'd1;
        for (int k = 0; k < 30; k++) begin
            adv_to(16 * k + 4);
            chk("R8 tone low gives zero", amp_c, 5'h00);
            adv_to(16 * k + 12);
            chk("R5 tone and noise combined", amp_c, m[0] ? 5'h1F : 5'h00);
            m = nstep(m);
        end

        // R5: both sources disabled stays silent.
        mix = 8'hFF; lvl_a = 5'h1F; lvl_b = 5'h0F; lvl_c = 5'h10; env_lvl = 5'h1F;
        do_reset();
        for (int k = 0; k < 8; k++) begin
            adv_to(13 * k + 5);
            chk("R5 both disabled A", amp_a, 5'h00);
            chk("R5 both disabled C", amp_c, 5'h00);
        end

        // R7: envelope followed live; fixed level zero gives code 1.
        mix = 8'b00_110_111; lvl_a = 5'h10; noise_per = 5'd4;
        do_reset();
        for (int k = 0; k < 5; k++) begin
            env_lvl = 5'(k * 7);
            adv_to(k + 1);
            chk("R7 envelope mode live", amp_a, 5'(k * 7));
        end
        lvl_a = 5'h00;
        adv_to(8);
        chk("R7 fixed level zero", amp_a, 5'h01);
        lvl_a = 5'h0C;
        adv_to(9);
        chk("R7 fixed level widened", amp_a, 5'h19);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule